// File: doc/BRIEF.md
# Ethernet Receive Preamble Gate

This block sits on the receive path directly behind the PHY byte interface. It watches every byte that arrives while the data-valid input is high. All bytes up to the first start-of-frame delimiter are treated as preamble. The block then decides whether the frame may continue downstream. Two independent enables control the decision. One rejects preambles whose content is wrong, meaning any byte other than the idle pattern or any byte received with the error line high. The other rejects preambles that are too long. With both enables clear, every preamble is accepted.

Frames that pass have their body bytes forwarded in order. Start and end markers are attached, so a later stage can frame the data without counting bytes. A frame that fails produces a one-cycle discard pulse and no body bytes. The gate then stays silent until data-valid drops.

Top module: `rx_preamble_gate`

## Requirements
- R1: After reset, `body_valid`, `body_sof`, `body_eof`, `drop_flag` and `body_byte` are all zero.
- R2: With `chk_content_en` high, a preamble containing any byte other than 0x55 before the delimiter 0xD5 causes a discard.
- R3: With `chk_content_en` high, `rx_er` high on any preamble byte, including the 0xD5 delimiter byte itself, causes a discard.
- R4: With `chk_content_en` low, preamble byte values and `rx_er` do not affect acceptance.
- R5: With `chk_length_en` high, a frame is discarded when 12 or more bytes precede the delimiter. A frame with 0 to 11 such bytes passes the length check.
- R6: With `chk_length_en` low, a preamble of any length passes the length check. This includes lengths far beyond the length limit, because the internal count saturates instead of wrapping.
- R7: On an accepted frame, the bytes after the delimiter appear on `body_byte` in order, each with `body_valid`. Take S as the cycle in which the delimiter is presented. The first body byte appears with `body_sof` after the third rising edge counted from S. `body_eof` marks the last body byte, released on the edge that samples `rx_dv` low.
- R8: On a discarded frame, `drop_flag` is high for exactly one cycle, following the edge that samples the delimiter. No body byte is emitted until `rx_dv` has been low, even when further 0xD5 bytes arrive.
- R9: If `rx_dv` falls before any delimiter is seen, `drop_flag` pulses for one cycle and nothing is emitted.
- R10: Only the first 0xD5 ends the preamble. Later 0xD5 bytes are forwarded as ordinary body data.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Receive byte clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_dv | input | 1 | Byte stream valid; low between frames |
| rx_er | input | 1 | Receive error flag for the current byte |
| rx_byte | input | 8 | Received byte |
| chk_content_en | input | 1 | Enable preamble content and error check |
| chk_length_en | input | 1 | Enable preamble length limit |
| body_valid | output | 1 | A body byte is on `body_byte` |
| body_byte | output | 8 | Forwarded frame byte |
| body_sof | output | 1 | Marks the first body byte |
| body_eof | output | 1 | Marks the last body byte |
| drop_flag | output | 1 | One-cycle discard pulse |

## Verification
A corrupted preamble count or content flag shows at the ports in the cycle after the delimiter. It appears as a discard pulse that should not be there, or one that is missing. In the same cycle, body output is wrongly suppressed or wrongly released. A faulty state sequence can leak body bytes from a discarded frame, or re-arm on a later 0xD5. That shows within three cycles as unexpected `body_valid` beats. A fault in the hold stage shows as a shifted start marker, a missing end marker or reordered bytes on the first or last byte of the frame. The sweep covers every preamble length around the limit, plus one far beyond it. Each length is run under each enable combination and each fault kind.

// File: rtl/rxpg_pkg.sv
// Package: shared constants and state type for the receive preamble gate.
// Assumes an 8-bit byte interface from the PHY.
package rxpg_pkg;
    localparam logic [7:0] PRE_BYTE = 8'h55;
    localparam logic [7:0] SFD_BYTE = 8'hD5;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PRE  = 2'd1,
        ST_BODY = 2'd2,
        ST_DROP = 2'd3
    } gate_state_t;
endpackage

// File: rtl/rxpg_pre_track.sv
// Module: rxpg_pre_track
// Counts preamble bytes, saturating at the limit, and remembers whether any
// preamble byte was wrong or flagged with an error. Assumes rx_dv is low
// between frames; the low time clears the record.
module rxpg_pre_track #(
    parameter int PRE_LIMIT = 12,
    parameter int CNT_W     = $clog2(PRE_LIMIT + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             rx_dv,
    input  logic             take,
    input  logic [7:0]       rx_byte,
    input  logic             rx_er,
    output logic [CNT_W-1:0] cnt,
    output logic             bad_seen,
    output logic             too_long
);
    import rxpg_pkg::*;

    localparam logic [CNT_W-1:0] LIMIT_V = CNT_W'(PRE_LIMIT);

    // Purpose: saturating count of preamble bytes and sticky content-fault flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt      <= '0;
            bad_seen <= 1'b0;
        end else if (!rx_dv) begin
            cnt      <= '0;
            bad_seen <= 1'b0;
        end else if (take) begin
            if (cnt != LIMIT_V) cnt <= cnt + 1'b1;
            if ((rx_byte != PRE_BYTE) || rx_er) bad_seen <= 1'b1;
        end
    end

    // Purpose: flag a preamble that has reached the length limit.
    always_comb too_long = (cnt >= LIMIT_V);

    // R6: counter never exceeds the limit, so it cannot wrap.
    a_r6_cnt_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        cnt <= LIMIT_V);

    // R6: once at the limit, more preamble bytes keep it there.
    a_r6_cnt_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (cnt == LIMIT_V && rx_dv && take) |=> (!rx_dv || cnt == LIMIT_V) || !$past(rst_n));
endmodule

// File: rtl/rxpg_ctrl.sv
// Module: rxpg_ctrl
// Frame state machine: finds the first delimiter, applies the enabled checks,
// and steers bytes into the body path or into discard. Assumes a frame starts
// on a rising rx_dv; a frame in progress at reset is ignored until rx_dv drops.
module rxpg_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_dv,
    input  logic       rx_er,
    input  logic [7:0] rx_byte,
    input  logic       chk_content_en,
    input  logic       chk_length_en,
    input  logic       bad_seen,
    input  logic       too_long,
    output logic       pre_take,
    output logic       body_start,
    output logic       body_take,
    output logic       body_end,
    output logic       drop_flag
);
    import rxpg_pkg::*;

    gate_state_t state, state_nx;
    logic        dv_q;
    logic        start, in_pre, is_sfd, sfd_hit, fail, lost_sfd;

    // Purpose: decode the current byte's role and the check outcome.
    always_comb begin
        start      = (state == ST_IDLE) && rx_dv && !dv_q;
        in_pre     = start || ((state == ST_PRE) && rx_dv);
        is_sfd     = (rx_byte == SFD_BYTE);
        pre_take   = in_pre && !is_sfd;
        sfd_hit    = in_pre && is_sfd;
        fail       = (chk_content_en && (bad_seen || rx_er)) ||
                     (chk_length_en && too_long);
        body_start = sfd_hit && !fail;
        body_take  = (state == ST_BODY) && rx_dv;
        body_end   = (state == ST_BODY) && !rx_dv;
        lost_sfd   = (state == ST_PRE) && !rx_dv;
    end

    // Purpose: next-state selection.
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (start) state_nx = is_sfd ? (fail ? ST_DROP : ST_BODY) : ST_PRE;
            ST_PRE:  if (!rx_dv) state_nx = ST_IDLE;
                     else if (is_sfd) state_nx = fail ? ST_DROP : ST_BODY;
            ST_BODY: if (!rx_dv) state_nx = ST_IDLE;
            ST_DROP: if (!rx_dv) state_nx = ST_IDLE;
            default: state_nx = ST_IDLE;
        endcase
    end

    // Purpose: state, previous-valid and discard pulse registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state     <= ST_IDLE;
            dv_q      <= 1'b1;
            drop_flag <= 1'b0;
        end else begin
            state     <= state_nx;
            dv_q      <= rx_dv;
            drop_flag <= (sfd_hit && fail) || lost_sfd;
        end
    end

    // R8: discard is a single-cycle pulse.
    a_r8_drop_single: assert property (@(posedge clk) disable iff (!rst_n)
        drop_flag |=> !drop_flag);

    // R8: while discarding, nothing enters the body path.
    a_r8_drop_blocks_body: assert property (@(posedge clk) disable iff (!rst_n)
        (drop_flag && rx_dv) |-> !body_take);
endmodule

// File: rtl/rxpg_body_out.sv
// Module: rxpg_body_out
// One-byte hold stage so the last body byte can carry the end marker when
// rx_dv falls. Assumes body_take and body_end are never high together.
module rxpg_body_out (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       body_start,
    input  logic       body_take,
    input  logic       body_end,
    input  logic [7:0] rx_byte,
    output logic       body_valid,
    output logic [7:0] body_byte,
    output logic       body_sof,
    output logic       body_eof
);
    logic       hold_v, hold_first, arm_first;
    logic [7:0] hold_b;

    // Purpose: load the hold register and release the previous byte with markers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v     <= 1'b0;
            hold_first <= 1'b0;
            arm_first  <= 1'b0;
            hold_b     <= '0;
            body_valid <= 1'b0;
            body_byte  <= '0;
            body_sof   <= 1'b0;
            body_eof   <= 1'b0;
        end else begin
            body_valid <= 1'b0;
            body_sof   <= 1'b0;
            body_eof   <= 1'b0;
            if (body_start) arm_first <= 1'b1;
            if (body_take) begin
                if (hold_v) begin
                    body_valid <= 1'b1;
                    body_byte  <= hold_b;
                    body_sof   <= hold_first;
                end
                hold_b     <= rx_byte;
                hold_v     <= 1'b1;
                hold_first <= arm_first;
                arm_first  <= 1'b0;
            end else if (body_end) begin
                if (hold_v) begin
                    body_valid <= 1'b1;
                    body_byte  <= hold_b;
                    body_sof   <= hold_first;
                    body_eof   <= 1'b1;
                end
                hold_v <= 1'b0;
            end
        end
    end

    // R7: after the frame ends the hold stage is empty.
    a_r7_hold_flushed: assert property (@(posedge clk) disable iff (!rst_n)
        body_end |=> !hold_v);
endmodule

// File: rtl/rx_preamble_gate.sv
// Module: rx_preamble_gate (top)
// Validates the receive preamble under two separate enables and forwards the
// frame body with start/end markers, or pulses a discard flag. Assumes a byte
// stream with rx_dv low for at least one cycle between frames.
module rx_preamble_gate #(
    parameter int PRE_LIMIT = 12
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_dv,
    input  logic       rx_er,
    input  logic [7:0] rx_byte,
    input  logic       chk_content_en,
    input  logic       chk_length_en,
    output logic       body_valid,
    output logic [7:0] body_byte,
    output logic       body_sof,
    output logic       body_eof,
    output logic       drop_flag
);
    localparam int CNT_W = $clog2(PRE_LIMIT + 1);

    logic [CNT_W-1:0] pre_cnt;
    logic             bad_seen, too_long;
    logic             pre_take, body_start, body_take, body_end;

    rxpg_pre_track #(.PRE_LIMIT(PRE_LIMIT), .CNT_W(CNT_W)) u_track (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .take(pre_take),
        .rx_byte(rx_byte), .rx_er(rx_er),
        .cnt(pre_cnt), .bad_seen(bad_seen), .too_long(too_long)
    );

    rxpg_ctrl u_ctrl (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er),
        .rx_byte(rx_byte), .chk_content_en(chk_content_en),
        .chk_length_en(chk_length_en), .bad_seen(bad_seen),
        .too_long(too_long), .pre_take(pre_take), .body_start(body_start),
        .body_take(body_take), .body_end(body_end), .drop_flag(drop_flag)
    );

    rxpg_body_out u_out (
        .clk(clk), .rst_n(rst_n), .body_start(body_start),
        .body_take(body_take), .body_end(body_end), .rx_byte(rx_byte),
        .body_valid(body_valid), .body_byte(body_byte),
        .body_sof(body_sof), .body_eof(body_eof)
    );

    // R8: a discard pulse never coincides with forwarded data.
    a_r8_no_data_on_drop: assert property (@(posedge clk) disable iff (!rst_n)
        drop_flag |-> !body_valid);

    // R7: markers only ride on valid bytes.
    a_r7_sof_valid: assert property (@(posedge clk) disable iff (!rst_n)
        (body_sof || body_eof) |-> body_valid);

    // R7: two idle cycles drain the output completely.
    a_r7_drains: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_dv ##1 !rx_dv) |=> !body_valid);
endmodule

// File: tb/rx_preamble_gate_bench.sv
module rx_preamble_gate_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_dv = 1'b0, rx_er = 1'b0;
    logic [7:0] rx_byte = '0;
    logic       chk_content_en = 1'b0, chk_length_en = 1'b0;
    logic       body_valid, body_sof, body_eof, drop_flag;
    logic [7:0] body_byte;

    int total = 0, bad = 0, cyc = 0;
    int nbody, nsof, neof, ndrop, sof_cyc, drop_cyc, sof_pos, eof_pos;
    logic [7:0] got [0:7];

    always #2 clk = ~clk;

    rx_preamble_gate u_rx_preamble_gate (
        .clk(clk), .rst_n(rst_n), .rx_dv(rx_dv), .rx_er(rx_er),
        .rx_byte(rx_byte), .chk_content_en(chk_content_en),
        .chk_length_en(chk_length_en), .body_valid(body_valid),
        .body_byte(body_byte), .body_sof(body_sof), .body_eof(body_eof),
        .drop_flag(drop_flag)
    );

    always @(posedge clk) cyc <= cyc + 1;

    always @(negedge clk) begin
        if (rst_n) begin
            if (body_valid) begin
                if (nbody < 8) got[nbody] = body_byte;
                if (body_sof) begin nsof++; sof_cyc = cyc; sof_pos = nbody; end
                if (body_eof) begin neof++; eof_pos = nbody; end
                nbody++;
            end
            if (drop_flag) begin ndrop++; drop_cyc = cyc; end
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic clear_mon();
        nbody = 0; nsof = 0; neof = 0; ndrop = 0;
        sof_cyc = -1; drop_cyc = -1; sof_pos = -1; eof_pos = -1;
    endtask

    function automatic logic [7:0] body_val(input int i);
        return (i == 0) ? 8'hD5 : 8'((i * 29 + 3) & 255);
    endfunction

    // kind: 0 clean, 1 wrong byte mid-preamble, 2 rx_er mid-preamble (or on delimiter)
    task automatic run_frame(input int plen, input int kind, input int blen,
                             input bit ce, input bit le);
        int sfd_c;
        bit fault, fail;
        int fidx;
        string tag;
        fidx = plen / 2;
        fault = (kind == 2) || (kind == 1 && plen > 0);
        fail = (ce && fault) || (le && plen >= 12);
        if (ce && fault) tag = (kind == 1) ? "R2" : "R3";
        else if (le && plen >= 12) tag = "R5";
        else if (!ce && fault) tag = "R4";
        else if (!le && plen >= 12) tag = "R6";
        else tag = "R7";
        clear_mon();
        chk_content_en = ce; chk_length_en = le;
        for (int i = 0; i < plen; i++) begin
            @(negedge clk);
            rx_dv = 1'b1;
            rx_byte = (kind == 1 && i == fidx) ? 8'h5D : 8'h55;
            rx_er = (kind == 2 && i == fidx);
        end
        @(negedge clk);
        rx_dv = 1'b1; rx_byte = 8'hD5; rx_er = (kind == 2 && plen == 0);
        sfd_c = cyc;
        for (int i = 0; i < blen; i++) begin
            @(negedge clk);
            rx_byte = body_val(i); rx_er = 1'b0;
        end
        @(negedge clk);
        rx_dv = 1'b0; rx_er = 1'b0; rx_byte = 8'h00;
        repeat (4) @(negedge clk);
        if (fail) begin
            chk(ndrop == 1, {tag, "/R8 drop"}, ndrop, 1);
            chk(drop_cyc == sfd_c + 1, {tag, "/R8 drop cycle"}, drop_cyc, sfd_c + 1);
            chk(nbody == 0, {tag, "/R8 no body"}, nbody, 0);
        end else begin
            chk(ndrop == 0, {tag, " no drop"}, ndrop, 0);
            chk(nbody == blen, {tag, "/R7 body count"}, nbody, blen);
            for (int i = 0; i < blen && i < 8; i++)
                chk(got[i] == body_val(i), {tag, "/R10 body byte"}, got[i], body_val(i));
            chk(nsof == 1 && sof_pos == 0, "R7 sof", sof_pos, 0);
            chk(neof == 1 && eof_pos == blen - 1, "R7 eof", eof_pos, blen - 1);
            chk(sof_cyc == sfd_c + 3, "R7 latency", sof_cyc, sfd_c + 3);
        end
    endtask

    initial begin
        clear_mon();
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state
        chk(!body_valid && !body_sof && !body_eof && !drop_flag && body_byte == 8'h00,
            "R1 reset outputs", {body_valid, body_sof, body_eof, drop_flag}, 0);

        // R9: rx_dv falls before any delimiter
        clear_mon();
        for (int i = 0; i < 5; i++) begin
            @(negedge clk); rx_dv = 1'b1; rx_byte = 8'h55;
        end
        @(negedge clk); rx_dv = 1'b0;
        repeat (4) @(negedge clk);
        chk(ndrop == 1, "R9 drop on missing delimiter", ndrop, 1);
        chk(nbody == 0, "R9 no body", nbody, 0);

        for (int ce = 0; ce < 2; ce++)
            for (int le = 0; le < 2; le++)
                for (int k = 0; k < 16; k++)
                    for (int kind = 0; kind < 3; kind++)
                        for (int b = 0; b < 2; b++)
                            run_frame((k == 15) ? 40 : k, kind, b ? 5 : 1, ce[0], le[0]);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=%0d expected=0", cyc);
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule